// File: doc/BRIEF.md
# Shared-RAM Six-Channel Byte FIFO Controller

The block keeps six byte FIFOs in one single-ported 1024-byte RAM: a transmit and a receive queue for each of three serial channels. Index 0 to 2 are the transmit queues and index 3 to 5 the receive queues. FIFO k has the fixed base address k×128. Its length is set by a 4-bit chunk count, with 128 bytes per chunk. Each FIFO keeps an 11-bit read pointer and an 11-bit write pointer. Both hold absolute RAM addresses.

Only the low 10 bits of a pointer reach the RAM. The regions are also not fenced off from one another. So a FIFO made larger than its 128-byte slot writes straight into the region of the next queue, and a pointer past 1023 aliases back into low memory. Both effects are kept on purpose.

Each FIFO has its own push and pop ports. A single arbiter grants one RAM access per cycle. Popped data comes back one cycle after the grant, on a shared data bus, with a per-FIFO valid strobe. A packed status word per FIFO shows both pointers.

Top module: `shared_fifo_ram`

## Requirements
- R1: While `rst_ni` is low, and after it is released, each pointer of FIFO k equals k×128, and `pop_valid_o` is zero.
- R2: The capacity of FIFO k is C = n×128 bytes, where n is its 4-bit chunk count (bits [4k+3:4k] of `size_i`); a count of 0 is treated as 1.
  - A pointer advances by one per accepted operation, using 11-bit arithmetic.
  - When the pointer equals (k×128 + C − 1) mod 2048, the next accepted operation loads k×128 instead.
- R3: Status word k is `status_o[32k+31:32k]`:
  - bits [1:0] are 0;
  - bits [12:2] hold the 11-bit read pointer;
  - bits [23:13] hold the 11-bit write pointer;
  - bits [31:24] are 0.
- R4: A FIFO is empty when its read pointer equals its write pointer. A pop request to an empty FIFO is refused: `pop_ready_o` stays low and no pointer moves.
- R5: A FIFO is full when it holds C − 1 bytes. A push to a full FIFO is refused: `push_ready_o` stays low and no pointer moves.
- R6: At most one of the twelve ready bits is high per cycle. Among the eligible requests, every push outranks every pop, and within each class the lower FIFO index wins. Requests that lose the arbitration see ready low.
- R7: A pop granted in cycle t raises `pop_valid_o[k]` alone in cycle t+1, with the byte on `pop_data_o`.
- R8: The RAM is addressed by pointer bits [9:0] only. Pointer values p and p+1024 reach the same byte.
- R9: There is no protection between regions. A write through any FIFO's pointer replaces the byte that another FIFO later reads at that address.
- R10: When no other FIFO writes into its range, each FIFO returns bytes in the order in which they were accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| size_i | input | 24 | Chunk count per FIFO, 4 bits each |
| push_valid_i | input | 6 | Push request per FIFO |
| push_data_i | input | 48 | Push byte per FIFO, 8 bits each |
| push_ready_o | output | 6 | Push accepted this cycle |
| pop_req_i | input | 6 | Pop request per FIFO |
| pop_ready_o | output | 6 | Pop accepted this cycle |
| pop_valid_o | output | 6 | Popped byte present, per FIFO |
| pop_data_o | output | 8 | Popped byte |
| status_o | output | 192 | Packed pointer status per FIFO, 32 bits each |

## Verification
The directed cases cover five situations:
- A chunk count of zero, filled to refusal and then drained to refusal. This separates the C−1 full threshold from off-by-one variants and shows the write pointer wrapping to base.
- A FIFO enlarged to two chunks that runs into its neighbour. This shows that the overwritten neighbour byte comes out of the neighbour's pop port.
- A 15-chunk FIFO driven past address 1023 and up to 1919. This tells a 10-bit RAM index apart from an 11-bit one, and the wrap at 1919 apart from a wrap at 2047.
- Random push and pop masks over all six FIFOs, with random sizes. These load the arbiter with simultaneous requests, so a wrong priority order or a wrong push-over-pop rule shows up as a ready mismatch.
- The same random runs with overlapping regions. These expose any misrouted address or data against a byte-level reference memory.

// File: rtl/sfr_pkg.sv
package sfr_pkg;
  localparam int NUM_FIFO_D   = 6;
  localparam int DATA_W_D     = 8;
  localparam int PTR_W_D      = 11;
  localparam int ADDR_W_D     = 10;
  localparam int SIZE_W_D     = 4;
  localparam int CHUNK_LOG2_D = 7;
  localparam int STATUS_W     = 32;
  localparam int STAT_RD_LSB  = 2;
endpackage

// File: rtl/sfr_arbiter.sv
module sfr_arbiter #(
  parameter int N = 12
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o
);
  // lowest index wins
  always_comb begin
    logic found;
    found = 1'b0;
    gnt_o = '0;
    for (int i = 0; i < N; i++) begin
      if (req_i[i] && !found) begin
        gnt_o[i] = 1'b1;
        found    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/sfr_fifo_ctrl.sv
module sfr_fifo_ctrl #(
  parameter int PTR_W      = 11,
  parameter int SIZE_W     = 4,
  parameter int CHUNK_LOG2 = 7,
  parameter int BASE       = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SIZE_W-1:0] size_i,
  input  logic              push_i,
  input  logic              pop_i,
  output logic [PTR_W-1:0]  wr_ptr_o,
  output logic [PTR_W-1:0]  rd_ptr_o,
  output logic              full_o,
  output logic              empty_o
);
  localparam logic [PTR_W-1:0] BASE_P = PTR_W'(BASE);

  logic [SIZE_W-1:0] chunks;
  logic [PTR_W-1:0]  cap, limit, wr_off, rd_off, occ;
  logic [PTR_W-1:0]  wr_q, rd_q;

  assign chunks = (size_i == '0) ? SIZE_W'(1) : size_i;
  assign cap    = PTR_W'(chunks) << CHUNK_LOG2;
  assign limit  = BASE_P + cap - PTR_W'(1);
  assign wr_off = wr_q - BASE_P;
  assign rd_off = rd_q - BASE_P;
  assign occ    = (wr_off >= rd_off) ? (wr_off - rd_off) : (wr_off + cap - rd_off);
  assign empty_o = (wr_q == rd_q);
  assign full_o  = (occ == cap - PTR_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q <= BASE_P;
      rd_q <= BASE_P;
    end else begin
      if (push_i) wr_q <= (wr_q == limit) ? BASE_P : wr_q + PTR_W'(1);
      if (pop_i)  rd_q <= (rd_q == limit) ? BASE_P : rd_q + PTR_W'(1);
    end
  end

  assign wr_ptr_o = wr_q;
  assign rd_ptr_o = rd_q;

  assert_no_push_full_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> !push_i);
  assert_no_pop_empty_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o |-> !pop_i);
  assert_wr_wrap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && wr_q == limit) |=> (wr_q == BASE_P));
  assert_wr_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && wr_q != limit) |=> (wr_q == $past(wr_q) + PTR_W'(1)));
endmodule

// File: rtl/sfr_ram.sv
module sfr_ram #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rdata_q;

  always_ff @(posedge clk_i) begin
    if (we_i) mem[addr_i] <= wdata_i;
    if (re_i) rdata_q <= mem[addr_i];
  end
  assign rdata_o = rdata_q;
endmodule

// File: rtl/shared_fifo_ram.sv
module shared_fifo_ram
  import sfr_pkg::*;
#(
  parameter int NUM_FIFO   = NUM_FIFO_D,
  parameter int DATA_W     = DATA_W_D,
  parameter int PTR_W      = PTR_W_D,
  parameter int ADDR_W     = ADDR_W_D,
  parameter int SIZE_W     = SIZE_W_D,
  parameter int CHUNK_LOG2 = CHUNK_LOG2_D
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [NUM_FIFO*SIZE_W-1:0]   size_i,
  input  logic [NUM_FIFO-1:0]          push_valid_i,
  input  logic [NUM_FIFO*DATA_W-1:0]   push_data_i,
  output logic [NUM_FIFO-1:0]          push_ready_o,
  input  logic [NUM_FIFO-1:0]          pop_req_i,
  output logic [NUM_FIFO-1:0]          pop_ready_o,
  output logic [NUM_FIFO-1:0]          pop_valid_o,
  output logic [DATA_W-1:0]            pop_data_o,
  output logic [NUM_FIFO*STATUS_W-1:0] status_o
);
  localparam int NREQ = 2 * NUM_FIFO;

  logic [PTR_W-1:0]    wr_ptr [NUM_FIFO];
  logic [PTR_W-1:0]    rd_ptr [NUM_FIFO];
  logic [NUM_FIFO-1:0] full, empty, push_gnt, pop_gnt, pop_valid_q;
  logic [NREQ-1:0]     req, gnt;
  logic [ADDR_W-1:0]   ram_addr;
  logic [DATA_W-1:0]   ram_wdata;
  logic                ram_we, ram_re;

  // pushes occupy low indices so they outrank pops
  assign req = {pop_req_i & ~empty, push_valid_i & ~full};

  sfr_arbiter #(.N(NREQ)) u_arb (.req_i(req), .gnt_o(gnt));

  assign push_gnt     = gnt[NUM_FIFO-1:0];
  assign pop_gnt      = gnt[NREQ-1:NUM_FIFO];
  assign push_ready_o = push_gnt;
  assign pop_ready_o  = pop_gnt;

  for (genvar g = 0; g < NUM_FIFO; g++) begin : g_fifo
    sfr_fifo_ctrl #(
      .PTR_W(PTR_W), .SIZE_W(SIZE_W), .CHUNK_LOG2(CHUNK_LOG2), .BASE(g << CHUNK_LOG2)
    ) u_ctrl (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .size_i  (size_i[g*SIZE_W +: SIZE_W]),
      .push_i  (push_gnt[g]),
      .pop_i   (pop_gnt[g]),
      .wr_ptr_o(wr_ptr[g]),
      .rd_ptr_o(rd_ptr[g]),
      .full_o  (full[g]),
      .empty_o (empty[g])
    );
    assign status_o[g*STATUS_W +: STATUS_W] =
      STATUS_W'({wr_ptr[g], rd_ptr[g], STAT_RD_LSB'(0)});
  end

  // top pointer bits are dropped: addresses alias modulo the RAM size
  always_comb begin
    ram_addr  = '0;
    ram_wdata = '0;
    for (int k = 0; k < NUM_FIFO; k++) begin
      if (push_gnt[k]) begin
        ram_addr  = wr_ptr[k][ADDR_W-1:0];
        ram_wdata = push_data_i[k*DATA_W +: DATA_W];
      end
      if (pop_gnt[k]) ram_addr = rd_ptr[k][ADDR_W-1:0];
    end
  end
  assign ram_we = |push_gnt;
  assign ram_re = |pop_gnt;

  sfr_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
    .clk_i  (clk_i),
    .we_i   (ram_we),
    .re_i   (ram_re),
    .addr_i (ram_addr),
    .wdata_i(ram_wdata),
    .rdata_o(pop_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pop_valid_q <= '0;
    else         pop_valid_q <= pop_gnt;
  end
  assign pop_valid_o = pop_valid_q;

  assert_one_grant_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({pop_ready_o, push_ready_o}));
  assert_pop_valid_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|pop_ready_o) |=> (pop_valid_o == $past(pop_ready_o)));
  assert_no_spurious_valid_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_ready_o == '0) |=> (pop_valid_o == '0));
endmodule

// File: tb/sim_shared_fifo_ram.sv
`timescale 1ns/1ps
module sim_shared_fifo_ram;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [23:0] size_i = '0;
  logic [5:0]  push_valid_i = '0, pop_req_i = '0;
  logic [47:0] push_data_i = '0;
  logic [5:0]  push_ready_o, pop_ready_o, pop_valid_o;
  logic [7:0]  pop_data_o;
  logic [191:0] status_o;

  always #2.5 clk = ~clk;

  shared_fifo_ram u0 (
    .clk_i(clk), .rst_ni(rst_ni), .size_i(size_i),
    .push_valid_i(push_valid_i), .push_data_i(push_data_i), .push_ready_o(push_ready_o),
    .pop_req_i(pop_req_i), .pop_ready_o(pop_ready_o), .pop_valid_o(pop_valid_o),
    .pop_data_o(pop_data_o), .status_o(status_o)
  );

  int vectors = 0, errors = 0;
  int m_wr [6], m_rd [6], m_size [6];
  logic [7:0] m_mem [1024];
  logic [5:0] exp_pv;
  logic [7:0] exp_pd;
  logic [5:0] obs_pv, obs_prdy, obs_qrdy;
  logic [7:0] obs_pd;
  logic [31:0] obs_stat [6];

  function automatic int m_cap(int i);
    return ((m_size[i] == 0) ? 1 : m_size[i]) * 128;
  endfunction
  function automatic int m_next(int i, int p);
    int lim = (i * 128 + m_cap(i) - 1) & 2047;
    return (p == lim) ? i * 128 : (p + 1) & 2047;
  endfunction
  function automatic int m_occ(int i);
    int wo = (m_wr[i] - i * 128) & 2047;
    int ro = (m_rd[i] - i * 128) & 2047;
    return (wo >= ro) ? wo - ro : wo + m_cap(i) - ro;
  endfunction
  function automatic logic [31:0] m_stat(int i);
    return (32'(m_wr[i]) << 13) | (32'(m_rd[i]) << 2);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [23:0] sz);
    @(negedge clk);
    rst_ni = 1'b0; size_i = sz; push_valid_i = '0; pop_req_i = '0;
    repeat (2) @(negedge clk);
    chk(pop_valid_o == '0, "R1 valid in reset", 32'(pop_valid_o), 0);
    rst_ni = 1'b1;
    for (int i = 0; i < 6; i++) begin
      m_size[i] = int'(sz[i*4 +: 4]);
      m_wr[i] = i * 128;
      m_rd[i] = i * 128;
    end
    exp_pv = '0;
  endtask

  task automatic step(input logic [5:0] pm, input logic [5:0] qm, input logic [47:0] pd);
    logic [11:0] egnt;
    @(negedge clk);
    chk(pop_valid_o === exp_pv, "R7 pop_valid", 32'(pop_valid_o), 32'(exp_pv));
    if (exp_pv != 0 && !$isunknown(exp_pd))
      chk(pop_data_o === exp_pd, "R10 pop_data", 32'(pop_data_o), 32'(exp_pd));
    obs_pv = pop_valid_o; obs_pd = pop_data_o;
    push_valid_i = pm; pop_req_i = qm; push_data_i = pd;
    #1;
    egnt = '0;
    for (int i = 0; i < 6 && egnt == 0; i++)
      if (pm[i] && m_occ(i) != m_cap(i) - 1) egnt[i] = 1'b1;
    for (int i = 0; i < 6 && egnt == 0; i++)
      if (qm[i] && m_wr[i] != m_rd[i]) egnt[6 + i] = 1'b1;
    chk({pop_ready_o, push_ready_o} === egnt, "R6 ready", 32'({pop_ready_o, push_ready_o}), 32'(egnt));
    obs_prdy = push_ready_o; obs_qrdy = pop_ready_o;
    for (int i = 0; i < 6; i++) begin
      obs_stat[i] = status_o[i*32 +: 32];
      chk(obs_stat[i] === m_stat(i), "R3 status", obs_stat[i], m_stat(i));
    end
    @(posedge clk);
    exp_pv = '0;
    for (int i = 0; i < 6; i++) begin
      if (egnt[i]) begin
        m_mem[m_wr[i] & 1023] = pd[i*8 +: 8];
        m_wr[i] = m_next(i, m_wr[i]);
      end
      if (egnt[6 + i]) begin
        exp_pd = m_mem[m_rd[i] & 1023];
        exp_pv[i] = 1'b1;
        m_rd[i] = m_next(i, m_rd[i]);
      end
    end
    #1;
    push_valid_i = '0; pop_req_i = '0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));

    // R1 reset state
    do_reset(24'h111111);
    step(6'h0, 6'h0, '0);
    for (int i = 0; i < 6; i++)
      chk(obs_stat[i] == ((32'(i * 128) << 13) | (32'(i * 128) << 2)), "R1 reset ptrs",
          obs_stat[i], (32'(i * 128) << 13) | (32'(i * 128) << 2));
    chk(obs_pv == '0, "R1 reset valid", 32'(obs_pv), 0);

    // R5/R4/R2: FIFO1 with chunk count 0 -> one chunk
    do_reset(24'h111101);
    for (int n = 0; n < 127; n++) step(6'h02, 6'h0, 48'(n) << 8);
    step(6'h02, 6'h0, 48'hEE << 8);
    chk(obs_prdy[1] == 1'b0, "R5 push refused when full", 32'(obs_prdy), 0);
    chk(obs_stat[1][23:13] == 11'h0FF, "R5 wr at 127 entries", 32'(obs_stat[1][23:13]), 32'h0FF);
    step(6'h0, 6'h02, '0);
    step(6'h0, 6'h0, '0);
    chk(obs_pd == 8'd0, "R10 first byte out", 32'(obs_pd), 0);
    for (int n = 0; n < 126; n++) step(6'h0, 6'h02, '0);
    step(6'h0, 6'h02, '0);
    chk(obs_qrdy[1] == 1'b0, "R4 pop refused when empty", 32'(obs_qrdy), 0);
    step(6'h02, 6'h0, 48'h55 << 8);
    step(6'h0, 6'h0, '0);
    chk(obs_stat[1][23:13] == 11'h080, "R2 wr wraps to base", 32'(obs_stat[1][23:13]), 32'h080);

    // R6 push beats pop, lower index first
    step(6'h30, 6'h02, 48'hAB_CD << 32);
    chk(obs_prdy == 6'h10 && obs_qrdy == 6'h0, "R6 priority", 32'({obs_qrdy, obs_prdy}), 32'h10);

    // R9: TX2 with two chunks overruns RX0
    do_reset(24'h111211);
    step(6'h08, 6'h0, 48'hA5 << 24);
    for (int n = 0; n < 128; n++) step(6'h04, 6'h0, 48'(n) << 16);
    step(6'h04, 6'h0, 48'h3C << 16);
    step(6'h0, 6'h08, '0);
    step(6'h0, 6'h0, '0);
    chk(obs_pv == 6'h08 && obs_pd == 8'h3C, "R9 neighbour overwritten", 32'(obs_pd), 32'h3C);

    // R8 and 11-bit wrap: TX0 with 15 chunks
    do_reset(24'h11111F);
    step(6'h08, 6'h0, 48'h11 << 24);
    for (int n = 0; n < 1408; n++) step(6'h01, 6'h0, 48'(n & 8'h7F));
    step(6'h01, 6'h0, 48'h77);
    step(6'h0, 6'h08, '0);
    step(6'h0, 6'h0, '0);
    chk(obs_stat[0][23:13] == 11'd1409, "R3 wr above 1023", 32'(obs_stat[0][23:13]), 1409);
    chk(obs_pd == 8'h77, "R8 alias modulo 1024", 32'(obs_pd), 32'h77);
    for (int n = 0; n < 510; n++) step(6'h01, 6'h0, 48'h5A);
    step(6'h01, 6'h0, 48'h5A);
    chk(obs_prdy[0] == 1'b0 && obs_stat[0][23:13] == 11'd1919, "R2 reaches 1919 full",
        32'(obs_stat[0][23:13]), 1919);
    step(6'h0, 6'h01, '0);
    step(6'h01, 6'h0, 48'h5A);
    step(6'h0, 6'h0, '0);
    chk(obs_stat[0][23:13] == 11'd0, "R2 wraps 1919 to 0", 32'(obs_stat[0][23:13]), 0);

    // random traffic with random sizes
    for (int r = 0; r < 4; r++) begin
      logic [23:0] sz;
      for (int i = 0; i < 6; i++) sz[i*4 +: 4] = 4'($urandom_range(0, 3));
      do_reset(sz);
      for (int n = 0; n < 2000; n++)
        step(6'($urandom), 6'($urandom), {16'($urandom), 32'($urandom)});
      step(6'h0, 6'h0, '0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule